// File: doc/BRIEF.md
# Display Window Line Parser

This block walks the display page memory in address order, beginning at location 0, and turns the stored entries into an ordered stream of items for one display window. Each line produces one skip-line item that carries its attribute, then one item per character, then an end-of-line marker. The window ends with a single window-end item. A start pulse at the beginning of each frame restarts the walk.

Each memory entry is 13 bits wide. The attribute sits in bits [12:9] and the 9-bit character code in bits [8:0]. The block drives a read address and gets the entry back on the read data port one clock later. Items leave on a valid/ready stream, so a slow consumer can hold the parser without any item being lost or repeated. If the walk reaches the last memory location and has not met an end-of-screen entry, the parser closes the window itself and raises an overflow flag.

Top module: `wlp_top`

## Requirements
- R1: After start, location 0 is read first. That entry, and the entry that follows each end-of-line entry, is emitted as a skip item (kind 0) carrying its code field and attribute field, whatever the code value.
- R2: Entries that follow a skip entry are emitted in address order as character items (kind 1), each carrying its own code and attribute, until an end-of-line or end-of-screen entry.
- R3: In a character position, an entry whose code field equals EOL_CODE (default 0x1FE) is emitted as a line-end item (kind 2) with code and attribute outputs zero.
- R4: In a character position, an entry whose code field is zero is emitted as a window-end item (kind 3) with code and attribute zero, whatever its attribute field. This closes the line and the window, and no further item is offered until the next start.
- R5: A zero entry immediately after an end-of-line entry is a skip item with code 0. It does not end the window.
- R6: If the entry at the last address (511) is consumed and is not an end-of-screen entry, its item is emitted first, then a window-end item, and overflow goes to 1. The overflow flag holds until the next start, and an end-of-screen entry at address 511 leaves overflow at 0.
- R7: While out_valid is 1 and out_ready is 0, out_kind, out_code and out_attr hold steady. Across any ready pattern, every entry's item is delivered exactly once and in order.
- R8: A start pulse in any state restarts the walk at location 0, discards an undelivered item and clears overflow.
- R9: After reset, out_valid is 0, overflow is 0 and rd_addr is 0, and no item is offered before a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame-begin pulse; restarts the walk at location 0 |
| rd_addr | output | 9 | Page memory read address |
| rd_data | input | 13 | Entry at the address presented one cycle earlier: attribute [12:9], code [8:0] |
| out_valid | output | 1 | An item is offered |
| out_ready | input | 1 | Consumer accepts the offered item |
| out_kind | output | 2 | 0 skip, 1 character, 2 line end, 3 window end |
| out_code | output | 9 | Skip parameter or character code; zero for end items |
| out_attr | output | 4 | Attribute of the item; zero for end items |
| overflow | output | 1 | Window closed at the last address without an end-of-screen entry |

## Verification
The bench aims at the places where slot position changes what an entry means. These are a zero and the end-of-line value sitting in a skip slot, an empty line, and an end-of-screen entry with a non-zero attribute. A parser that decoded entries without tracking the slot would end the window early or drop a line. Backpressure patterns and a long stall show whether an item is repeated or skipped while the read latency overlaps the hold. A mid-window restart catches a design that keeps a stale item or an old address. Filling the whole memory tests the last-address boundary three ways: with a character, with an end-of-line entry and with an end-of-screen entry. A design that wraps the address, misses the trailing window-end or raises overflow wrongly fails one of these.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
    localparam int CODE_W  = 9;
    localparam int ATTR_W  = 4;
    localparam int ENTRY_W = CODE_W + ATTR_W;

    typedef enum logic [1:0] {
        K_SKIP = 2'd0,
        K_CHAR = 2'd1,
        K_LEND = 2'd2,
        K_WEND = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_SL   = 2'd1,
        ST_READ_CHAR = 2'd2,
        ST_DONE      = 2'd3
    } state_e;

    typedef struct packed {
        kind_e               kind;
        logic [CODE_W-1:0]   code;
        logic [ATTR_W-1:0]   attr;
    } item_t;
endpackage

// File: rtl/wlp_classify.sv
module wlp_classify
    import wlp_pkg::*;
#(
    parameter logic [CODE_W-1:0] EOL_CODE = 9'h1FE
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               sl_slot,
    output item_t              item,
    output logic               is_eos,
    output logic               is_eol
);
    logic [CODE_W-1:0] code_w;
    logic [ATTR_W-1:0] attr_w;

    assign code_w = entry[CODE_W-1:0];
    assign attr_w = entry[ENTRY_W-1:CODE_W];

    always_comb begin
        is_eos = !sl_slot && (code_w == '0);
        is_eol = !sl_slot && (code_w == EOL_CODE);
        if (sl_slot) begin
            item = '{kind: K_SKIP, code: code_w, attr: attr_w};
        end else if (is_eos) begin
            item = '{kind: K_WEND, code: '0, attr: '0};
        end else if (is_eol) begin
            item = '{kind: K_LEND, code: '0, attr: '0};
        end else begin
            item = '{kind: K_CHAR, code: code_w, attr: attr_w};
        end
    end
endmodule

// File: rtl/wlp_ctrl.sv
module wlp_ctrl
    import wlp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              slot_free,
    input  item_t             item_in,
    input  logic              is_eos,
    input  logic              is_eol,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sl_slot,
    output logic              load,
    output item_t             load_item,
    output logic              overflow
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] addr;
        logic              lat;
        logic              pend;
        logic              ovf;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        load      = 1'b0;
        load_item = item_in;
        if (start) begin
            ctl_d.state = ST_READ_SL;
            ctl_d.addr  = '0;
            ctl_d.lat   = 1'b1;
            ctl_d.pend  = 1'b0;
            ctl_d.ovf   = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_READ_SL, ST_READ_CHAR: begin
                    if (ctl_q.lat) begin
                        ctl_d.lat = 1'b0;
                    end else if (slot_free) begin
                        load = 1'b1;
                        if (ctl_q.state == ST_READ_CHAR && is_eos) begin
                            ctl_d.state = ST_DONE;
                        end else begin
                            if (ctl_q.state == ST_READ_SL) begin
                                ctl_d.state = ST_READ_CHAR;
                            end else if (is_eol) begin
                                ctl_d.state = ST_READ_SL;
                            end
                            if (ctl_q.addr == LAST) begin
                                ctl_d.state = ST_DONE;
                                ctl_d.pend  = 1'b1;
                            end else begin
                                ctl_d.addr = ctl_q.addr + 1'b1;
                                ctl_d.lat  = 1'b1;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    if (ctl_q.pend && slot_free) begin
                        load       = 1'b1;
                        load_item  = '{kind: K_WEND, code: '0, attr: '0};
                        ctl_d.pend = 1'b0;
                        ctl_d.ovf  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, addr: '0, lat: 1'b0, pend: 1'b0, ovf: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_addr  = ctl_q.addr;
    assign sl_slot  = (ctl_q.state == ST_READ_SL);
    assign overflow = ctl_q.ovf;

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.addr == LAST && !start) |=> (ctl_q.addr == LAST));

    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_DONE && !start) |=> (ctl_q.state == ST_DONE));
endmodule

// File: rtl/wlp_outreg.sv
module wlp_outreg
    import wlp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  load,
    input  item_t item_in,
    input  logic  ready,
    output logic  valid,
    output item_t item,
    output logic  free
);
    typedef struct packed {
        logic  valid;
        item_t item;
    } slot_t;

    slot_t slot_d, slot_q;

    assign free = !slot_q.valid || ready;

    always_comb begin
        slot_d = slot_q;
        if (flush) begin
            slot_d.valid = 1'b0;
        end else if (load) begin
            slot_d.valid = 1'b1;
            slot_d.item  = item_in;
        end else if (ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{valid: 1'b0, item: '{kind: K_SKIP, code: '0, attr: '0}};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign item  = slot_q.item;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !ready && !flush) |=> (slot_q.valid && $stable(slot_q.item)));
endmodule

// File: rtl/wlp_top.sv
module wlp_top
    import wlp_pkg::*;
#(
    parameter int                ADDR_W   = 9,
    parameter logic [CODE_W-1:0] EOL_CODE = 9'h1FE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_kind,
    output logic [CODE_W-1:0]  out_code,
    output logic [ATTR_W-1:0]  out_attr,
    output logic               overflow
);
    item_t dec_item, load_item, out_item;
    logic  dec_eos, dec_eol, sl_slot, load, slot_free;

    wlp_classify #(.EOL_CODE(EOL_CODE)) u_classify (
        .entry   (rd_data),
        .sl_slot (sl_slot),
        .item    (dec_item),
        .is_eos  (dec_eos),
        .is_eol  (dec_eol)
    );

    wlp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .slot_free (slot_free),
        .item_in   (dec_item),
        .is_eos    (dec_eos),
        .is_eol    (dec_eol),
        .rd_addr   (rd_addr),
        .sl_slot   (sl_slot),
        .load      (load),
        .load_item (load_item),
        .overflow  (overflow)
    );

    wlp_outreg u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (start),
        .load    (load),
        .item_in (load_item),
        .ready   (out_ready),
        .valid   (out_valid),
        .item    (out_item),
        .free    (slot_free)
    );

    assign out_kind = out_item.kind;
    assign out_code = out_item.code;
    assign out_attr = out_item.attr;

    // R4
    win_end_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_kind == K_WEND && !start) |=> !out_valid);

    // R6
    ovf_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (out_valid && out_kind == K_WEND));
endmodule

// File: tb/tb_wlp_top.sv
module tb_wlp_top;
    import wlp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  rd_addr;
    logic [12:0] rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_kind;
    logic [8:0]  out_code;
    logic [3:0]  out_attr;
    logic        overflow;

    logic [12:0] mem [512];
    logic [1:0]  gk [600];
    logic [8:0]  gc [600];
    logic [3:0]  ga [600];
    int          ng;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) rd_data <= mem[rd_addr];

    wlp_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_code(out_code), .out_attr(out_attr), .overflow(overflow)
    );

    // entry[27:15], kind[14:13], code[12:4], attr[3:0]
    localparam int NA = 9;
    localparam logic [27:0] VEC [NA] = '{
        {4'h3, 9'h005, 2'd0, 9'h005, 4'h3},
        {4'h3, 9'h041, 2'd1, 9'h041, 4'h3},
        {4'h7, 9'h142, 2'd1, 9'h142, 4'h7},
        {4'h0, 9'h1FE, 2'd2, 9'h000, 4'h0},
        {4'h2, 9'h000, 2'd0, 9'h000, 4'h2},
        {4'h5, 9'h1FE, 2'd2, 9'h000, 4'h0},
        {4'h1, 9'h1FE, 2'd0, 9'h1FE, 4'h1},
        {4'hF, 9'h1FF, 2'd1, 9'h1FF, 4'hF},
        {4'h6, 9'h000, 2'd3, 9'h000, 4'h0}
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int i, input logic [1:0] k);
        if (i == 4) return "R5";
        case (k)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic load_table();
        for (int a = 0; a < 512; a++) mem[a] = {4'h1, 9'h077};
        for (int i = 0; i < NA; i++) mem[i] = VEC[i][27:15];
    endtask

    task automatic run_window(input int mode);
        pulse_start();
        ng = 0;
        for (int k = 0; k < 5000; k++) begin
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = (cyc % 8) >= 5;
            endcase
            if (out_valid && out_ready) begin
                gk[ng] = out_kind; gc[ng] = out_code; ga[ng] = out_attr;
                ng++;
                if (out_kind == 2'd3 || ng >= 600) break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        chk(overflow == 1'b0, "R9", "overflow in reset", overflow, 0);
        chk(rd_addr == 9'd0, "R9", "rd_addr in reset", rd_addr, 0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk(seen == 0, "R9", "items before start", seen, 0);
        end

        // table walk under three ready patterns
        for (int mode = 0; mode < 3; mode++) begin
            load_table();
            run_window(mode);
            chk(ng == NA, (mode == 0) ? "R4" : "R7", "item count", ng, NA);
            for (int i = 0; i < NA; i++) begin
                chk(gk[i] == VEC[i][14:13], req_of(i, VEC[i][14:13]), "kind", gk[i], VEC[i][14:13]);
                chk(gc[i] == VEC[i][12:4], req_of(i, VEC[i][14:13]), "code", gc[i], VEC[i][12:4]);
                chk(ga[i] == VEC[i][3:0], req_of(i, VEC[i][14:13]), "attr", ga[i], VEC[i][3:0]);
            end
            begin
                int extra = 0;
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    if (out_valid) extra++;
                end
                chk(extra == 0, "R4", "items after window end", extra, 0);
            end
            chk(overflow == 1'b0, "R6", "overflow after normal end", overflow, 0);
        end

        // stall hold and mid-window restart
        load_table();
        pulse_start();
        out_ready = 1'b1;
        begin
            int n = 0;
            logic [8:0] hc;
            logic [1:0] hk;
            for (int k = 0; k < 100 && n < 3; k++) begin
                if (out_valid) n++;
                @(negedge clk);
            end
            out_ready = 1'b0;
            for (int k = 0; k < 10 && !out_valid; k++) @(negedge clk);
            hc = out_code; hk = out_kind;
            repeat (5) @(negedge clk);
            chk(out_valid == 1'b1, "R7", "valid held in stall", out_valid, 1);
            chk(out_code == hc && out_kind == hk, "R7", "item held in stall", out_code, hc);
        end
        run_window(0);
        chk(ng == NA, "R8", "count after restart", ng, NA);
        chk(gk[0] == 2'd0 && gc[0] == 9'h005, "R8", "first item after restart", gc[0], 9'h005);
        chk(gk[3] == 2'd2, "R8", "fourth item after restart", gk[3], 2);

        // last address holds a character
        mem[0] = {4'h2, 9'h010};
        for (int a = 1; a < 512; a++) mem[a] = {4'h1, 9'h041};
        run_window(0);
        chk(ng == 513, "R6", "count, char at last", ng, 513);
        chk(gk[511] == 2'd1 && gc[511] == 9'h041, "R6", "item at last address", gk[511], 1);
        chk(gk[512] == 2'd3, "R6", "closing window end", gk[512], 3);
        chk(overflow == 1'b1, "R6", "overflow set", overflow, 1);
        repeat (4) @(negedge clk);
        chk(overflow == 1'b1, "R6", "overflow sticky", overflow, 1);

        // last address holds end-of-line
        mem[511] = {4'h0, 9'h1FE};
        run_window(1);
        chk(ng == 513, "R6", "count, eol at last", ng, 513);
        chk(gk[511] == 2'd2, "R6", "line end at last", gk[511], 2);
        chk(gk[512] == 2'd3, "R6", "window end after eol at last", gk[512], 3);
        chk(overflow == 1'b1, "R6", "overflow after eol at last", overflow, 1);

        // last address holds end-of-screen
        mem[511] = '0;
        run_window(0);
        chk(ng == 512, "R6", "count, eos at last", ng, 512);
        chk(gk[511] == 2'd3, "R6", "window end at last", gk[511], 3);
        chk(overflow == 1'b0, "R8", "overflow cleared by start", overflow, 0);

        summary();
    end
endmodule